// File: doc/BRIEF.md
# PWM Falling-Edge Dead-Band Delay

This block derives a gated PWM output from one PWM input. The output's rising edge tracks the input in the same cycle. Its falling edge is held back by a programmable number of clock cycles. A rising input edge cancels a countdown that is still running, so a low pulse shorter than the delay never reaches the output. A low enable input bypasses the delay path, and the output then follows the input directly.

The delay is loaded in two steps. A register write lands in a shadow copy. The shadow copy moves into the active copy on a strobe from the free-running PWM counter when it reaches zero. In immediate mode any such strobe commits a pending value. In synchronous mode the commit waits for the first zero strobe after a global update request. A later write before the commit replaces the earlier pending value, so the earlier value is never applied.

Top module: `pwm_fall_delay`

## Requirements
- R1: After reset the shadow and active delays are 0, `rd_data_o` reads 0, and `pwm_o` falls in the same cycle as `pwm_i`.
- R2: A write (`wr_en_i`=1) stores `wr_data_i[11:0]` as the shadow delay. `rd_data_o` returns the latest written delay in bits [11:0]. Bits [31:12] always read 0 and ignore the written data.
- R3: With `en_i`=0, `pwm_o` equals `pwm_i` in every cycle, whatever the delay is, and any running countdown is cleared.
- R4: With `en_i`=1 and active delay N, `pwm_o` falls exactly N cycles after the cycle in which `pwm_i` goes low (N=0: the same cycle). It then stays low until `pwm_i` rises.
- R5: If the active delay is at least as long as a low pulse on `pwm_i`, `pwm_o` has no low cycle for that pulse.
- R6: With `sync_mode_i`=0, a written value becomes active at the first cycle with `cnt_zero_i`=1 after the write. Until then the previous delay stays in use.
- R7: With `sync_mode_i`=1, a pending value becomes active only at the first `cnt_zero_i` strobe that comes in a later cycle than a `sync_req_i` pulse. Zero strobes before any request leave the active delay unchanged.
- R8: If the shadow is written again before a pending value commits, only the latest value is committed. The earlier value is never active.
- R9: `pwm_o` is high in every cycle in which `pwm_i` is high. A rise of `pwm_i` during a countdown cancels the countdown with no low cycle on `pwm_o`.
- R10: A synchronous request is consumed by the next zero strobe even if nothing is pending. A request with no new write leaves the active delay unchanged, and a write after that consumption needs a fresh request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Dead-band enable; 0 bypasses the delay |
| pwm_i | input | 1 | PWM input signal |
| cnt_zero_i | input | 1 | One-cycle strobe: PWM counter reached zero |
| sync_mode_i | input | 1 | Update mode: 0 immediate, 1 synchronous |
| sync_req_i | input | 1 | Global synchronous-update request pulse |
| wr_en_i | input | 1 | Delay register write strobe |
| wr_data_i | input | 32 | Write data; bits [11:0] hold the delay |
| rd_data_o | output | 32 | Delay register read value (shadow copy) |
| pwm_o | output | 1 | Delayed-fall PWM output |

## Verification
The assertions assume that `cnt_zero_i`, `sync_req_i` and `wr_en_i` are synchronous single-cycle strobes. They also assume that `pwm_i` changes only between clock edges. The zero-delay property further assumes that the active delay is stable while a fall is evaluated, which holds because commits happen only on zero strobes. The bench drives every input on the falling clock edge and raises each strobe for exactly one cycle. It changes the delay only while `pwm_i` is high, so no countdown straddles a commit.

// File: rtl/pwm_fall_delay_pkg.sv
`timescale 1ns/1ps
package pwm_fall_delay_pkg;
  typedef enum logic {
    UPD_IMM  = 1'b0,
    UPD_SYNC = 1'b1
  } upd_mode_e;
endpackage

// File: rtl/pfd_shadow.sv
`timescale 1ns/1ps
module pfd_shadow
  import pwm_fall_delay_pkg::*;
#(
  parameter int DW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_dly_i,
  input  logic          cnt_zero_i,
  input  upd_mode_e     mode_i,
  input  logic          sync_req_i,
  output logic [DW-1:0] shadow_o,
  output logic [DW-1:0] act_o
);
  logic [DW-1:0] shadow_q, act_q;
  logic          pend_q, armed_q, commit;

  // sync request must precede the zero strobe by at least one cycle
  always_comb begin
    commit = 1'b0;
    if (cnt_zero_i && pend_q)
      commit = (mode_i == UPD_IMM) || armed_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      act_q    <= '0;
      pend_q   <= 1'b0;
      armed_q  <= 1'b0;
    end else begin
      if (wr_en_i) shadow_q <= wr_dly_i;
      if (commit)  act_q    <= shadow_q;
      if (wr_en_i)     pend_q <= 1'b1;
      else if (commit) pend_q <= 1'b0;
      if (sync_req_i)      armed_q <= 1'b1;
      else if (cnt_zero_i) armed_q <= 1'b0;
    end
  end

  assign shadow_o = shadow_q;
  assign act_o    = act_q;
endmodule

// File: rtl/pfd_fall_ctr.sv
`timescale 1ns/1ps
module pfd_fall_ctr #(
  parameter int DW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          pwm_i,
  input  logic [DW-1:0] act_i,
  output logic          pwm_o
);
  logic          in_q, fall, busy, act_nz;
  logic [DW-1:0] cnt_q, cnt_d;

  assign act_nz = (act_i != '0);
  assign fall   = in_q & ~pwm_i;
  assign busy   = (fall & act_nz) | (cnt_q != '0);
  assign pwm_o  = en_i ? (pwm_i | busy) : pwm_i;

  // cnt_q holds cycles of high still owed after the current one
  always_comb begin
    cnt_d = cnt_q;
    if (!en_i || pwm_i)    cnt_d = '0;
    else if (fall)         cnt_d = act_nz ? act_i - 1'b1 : '0;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      in_q  <= pwm_i;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/pwm_fall_delay.sv
`timescale 1ns/1ps
module pwm_fall_delay
  import pwm_fall_delay_pkg::*;
#(
  parameter int DLY_W = 12,
  parameter int REG_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             pwm_i,
  input  logic             cnt_zero_i,
  input  logic             sync_mode_i,
  input  logic             sync_req_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             pwm_o
);
  localparam int PAD_W = REG_W - DLY_W;

  logic [DLY_W-1:0] shadow_w, act_w;
  upd_mode_e        mode;

  assign mode = upd_mode_e'(sync_mode_i);

  pfd_shadow #(.DW(DLY_W)) u_shadow (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_dly_i   (wr_data_i[DLY_W-1:0]),
    .cnt_zero_i (cnt_zero_i),
    .mode_i     (mode),
    .sync_req_i (sync_req_i),
    .shadow_o   (shadow_w),
    .act_o      (act_w)
  );

  pfd_fall_ctr #(.DW(DLY_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .pwm_i  (pwm_i),
    .act_i  (act_w),
    .pwm_o  (pwm_o)
  );

  assign rd_data_o = {{PAD_W{1'b0}}, shadow_w};
endmodule

// File: rtl/pwm_fall_delay_chk.sv
`timescale 1ns/1ps
module pwm_fall_delay_chk #(
  parameter int DW = 12,
  parameter int RW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic          pwm_i,
  input logic          pwm_o,
  input logic          cnt_zero_i,
  input logic          wr_en_i,
  input logic [RW-1:0] wr_data_i,
  input logic [RW-1:0] rd_data_o,
  input logic [DW-1:0] act_i
);
  a_r9_high_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwm_i |-> pwm_o);

  a_r3_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (pwm_o == pwm_i));

  a_r2_rd_latest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (rd_data_o[DW-1:0] == $past(wr_data_i[DW-1:0])));

  a_r2_upper_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (wr_data_i[RW-1:DW] != '0)) |=> (rd_data_o[RW-1:DW] == '0));

  a_r4_zero_same_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(pwm_i) && en_i && (act_i == '0)) |-> !pwm_o);

  a_r6_hold_between_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_zero_i |=> $stable(act_i));
endmodule

bind pwm_fall_delay pwm_fall_delay_chk #(.DW(DLY_W), .RW(REG_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .pwm_i      (pwm_i),
  .pwm_o      (pwm_o),
  .cnt_zero_i (cnt_zero_i),
  .wr_en_i    (wr_en_i),
  .wr_data_i  (wr_data_i),
  .rd_data_o  (rd_data_o),
  .act_i      (act_w)
);

// File: tb/pwm_fall_delay_tb_top.sv
`timescale 1ns/1ps
module pwm_fall_delay_tb_top;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        en_i = 1'b1, pwm_i = 1'b1, cnt_zero_i = 1'b0;
  logic        sync_mode_i = 1'b0, sync_req_i = 1'b0, wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic        pwm_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  pwm_fall_delay dut_i (.*);

  // {delay, low length}: delay < length gives delayed fall, else swallowed pulse
  localparam int NV = 7;
  localparam int VEC [NV][2] = '{
    '{0, 8}, '{1, 8}, '{3, 8}, '{7, 8}, '{8, 8}, '{12, 5}, '{40, 50}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic strobe(input int which);
    @(negedge clk_i);
    case (which)
      0: cnt_zero_i = 1'b1;
      default: sync_req_i = 1'b1;
    endcase
    @(negedge clk_i);
    cnt_zero_i = 1'b0;
    sync_req_i = 1'b0;
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1;
    wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  // high 4, low len, high 4; first = index of first low output cycle (-1 none)
  task automatic pulse(input int len, output int first, output int lows,
                       output int high_bad);
    first = -1; lows = 0; high_bad = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i); pwm_i = 1'b1; #1;
      if (!pwm_o) high_bad++;
    end
    for (int i = 0; i < len; i++) begin
      @(negedge clk_i); pwm_i = 1'b0; #1;
      if (!pwm_o) begin
        lows++;
        if (first < 0) first = i;
      end
    end
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i); pwm_i = 1'b1; #1;
      if (!pwm_o) high_bad++;
    end
  endtask

  task automatic expect_dly(input int len, input int d, input string req);
    int f, l, hb, ef, el;
    pulse(len, f, l, hb);
    ef = (d < len) ? d : -1;
    el = (d < len) ? len - d : 0;
    chk(f == ef, req, f, ef);
    chk(l == el, req, l, el);
    chk(hb == 0, "R9 high follows input", hb, 0);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    chk(rd_data_o == 32'h0, "R1 reset read", rd_data_o, 0);
    expect_dly(6, 0, "R1 reset zero delay");

    // R2 upper bits dropped; R6 not active before zero strobe
    wr(32'hFFFF_F123);
    #1;
    chk(rd_data_o == 32'h0000_0123, "R2 read masked", rd_data_o, 32'h123);
    expect_dly(6, 0, "R6 held until zero");
    strobe(0);
    expect_dly(300, 32'h123, "R6 commit at zero");

    // table walk, immediate mode: R4 exact delay, R5 swallowed pulses, R9 cancel
    for (int v = 0; v < NV; v++) begin
      wr(VEC[v][0]);
      strobe(0);
      expect_dly(VEC[v][1], VEC[v][0], (VEC[v][0] < VEC[v][1]) ? "R4 delay" : "R5 swallow");
    end

    // R3 bypass
    wr(5); strobe(0);
    en_i = 1'b0;
    expect_dly(8, 0, "R3 bypass");
    en_i = 1'b1;
    expect_dly(8, 5, "R3 re-enabled");

    // R7 synchronous mode
    sync_mode_i = 1'b1;
    wr(9); strobe(0);
    expect_dly(20, 5, "R7 zero without request");
    strobe(1); strobe(0);
    expect_dly(20, 9, "R7 commit after request");

    // R10 request consumed, no write -> unchanged
    strobe(1); strobe(0);
    expect_dly(20, 9, "R10 request without write");
    wr(2); strobe(0);
    expect_dly(20, 9, "R10 request consumed");
    strobe(1); strobe(0);
    expect_dly(20, 2, "R10 fresh request");

    // R8 rewrite before commit, both modes
    sync_mode_i = 1'b0;
    wr(4); wr(6); strobe(0);
    expect_dly(20, 6, "R8 latest wins immediate");
    sync_mode_i = 1'b1;
    wr(3); strobe(1); wr(11); strobe(0);
    expect_dly(20, 11, "R8 latest wins sync");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule